// File: doc/BRIEF.md
# Indexed Register Target on a Two-Wire Serial Bus

This block is a target-only endpoint on a two-wire serial bus (I2C-style START, STOP, 7-bit address, ACK/NACK). It never drives SCL and never starts a transfer. Every element inside it is reached through one 8-bit index. The first byte after the address in any write transfer loads the index, and the bytes that follow are written to the element that the index selects. A read transfer carries no index byte and returns data from the element the index currently selects. A host therefore sets the index with a short write and then reads, either in a separate transfer or after a repeated START.

Control, status and identity registers are selected directly by index. Two memories are reached only through a pointer register and a data-port register each. The first memory is a small RAM with a linear pointer. The second is a nonvolatile-style byte matrix whose pointer holds separate row and column fields. Only some column values exist in that matrix, so its address space has gaps. Internal event pulses set sticky status bits. A level interrupt output tells the host that an enabled status bit is set, so the host does not have to poll.

Index map: 0x00 control (8 bits, read/write), 0x01 event status (write 1 to clear), 0x02 interrupt enable, 0x03 identity (read-only), 0x04 RAM pointer, 0x05 RAM data port, 0x06 matrix pointer, 0x07 matrix data port. All other index values are unmapped.

Top module: `i2c_idx_slave`

## Requirements
- R1: The block ACKs (drives SDA low in the ninth clock) only an address byte whose upper seven bits equal SLV_ADDR (default 0x2C). Any other address gets no ACK, and the block ignores all later bytes until the next START.
- R2: In a write transfer, the byte after the address loads the index. Each later byte writes the element at the index: 0x00 control, 0x01 status, 0x02 enable, 0x04 RAM pointer, 0x05 RAM data, 0x06 matrix pointer, 0x07 matrix data.
- R3: A read transfer (address LSB 1) returns bytes from the element at the current index. This holds both after a STOP and after a repeated START that follows an index write.
- R4: After each data byte written or read at an index other than 0x05 or 0x07, the index increments by one, wrapping from 0xFF to 0x00. The index changes only on an index load or on such a data byte.
- R5: Index 0x03 reads the constant ID_VAL (default 0xA5), and writes to it are discarded. Enable bits 7:4 read as 0 and ignore writes. Unmapped indices read 0x00 and ignore writes.
- R6: Each data byte at index 0x05 reads or writes RAM[pointer] and then increments the RAM pointer, which wraps at RAM_DEPTH (default 16). The index stays at 0x05.
- R7: The matrix pointer holds the row in bits 6:4 and the column in bits 3:0, and bit 7 reads 0. Each data byte at 0x07 advances the column. After the last column (NV_COLS-1 = 11), or from any larger column, the column returns to 0 and the row advances. The row wraps to 0 after row NV_ROWS-1 = 5. The index stays at 0x07.
- R8: Matrix cells read 0xFF after reset. A pointer whose row is 6 or more, or whose column is 12 or more, reads 0xFF and discards writes, and the pointer still advances.
- R9: A pulse on event_i[k] sets status bit k, which stays set until a data write to 0x01 with bit k = 1. If an event and a clear arrive in the same cycle, the event wins.
- R10: irq_o is high exactly when some status bit and its enable bit are both 1.
- R11: A START or STOP at any point aborts the partial byte and returns the byte engine to address reception, with SDA released.
- R12: sda_oe_o changes only while SCL is low.
- R13: A read ends when the host NACKs. Only the bytes actually sent advance the index or pointer, and SDA is released for the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| event_i | input | N_EVT | Internal event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions assume SCL and SDA each stay stable for many system clocks. They also assume SDA changes only while SCL is low, except at START and STOP. Under those conditions the two-flop synchronisers and the edge detector produce one clean event per bus edge. The bench master holds every SCL phase for 16 system clocks and changes SDA only in the middle of the low phase. It raises event pulses only while the bus is idle, so register writes and events never have to be ordered against each other in the reference model. The check that drive changes happen only with SCL low relies on the same wide low phase, because the block answers a falling SCL edge a few clocks later.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;
  localparam logic [7:0] IDX_CTRL = 8'h00;
  localparam logic [7:0] IDX_STAT = 8'h01;
  localparam logic [7:0] IDX_IEN  = 8'h02;
  localparam logic [7:0] IDX_ID   = 8'h03;
  localparam logic [7:0] IDX_RPTR = 8'h04;
  localparam logic [7:0] IDX_RDAT = 8'h05;
  localparam logic [7:0] IDX_NPTR = 8'h06;
  localparam logic [7:0] IDX_NDAT = 8'h07;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_WR, LS_WR_ACK, LS_RD, LS_RD_ACK
  } link_state_e;
endpackage

// File: rtl/i2c_idx_sync.sv
module i2c_idx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;  // bit 0 scl, bit 1 sda

  logic [NLINES-1:0] line_raw, line_s, line_d;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], line_raw[g]};
    end
    assign line_s[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_d <= '1;
    else         line_d <= line_s;
  end

  assign sda_o      = line_s[1];
  assign scl_rise_o = line_s[0] & ~line_d[0];
  assign scl_fall_o = ~line_s[0] & line_d[0];
  assign start_o    = line_s[0] & line_d[0] & line_d[1] & ~line_s[1];
  assign stop_o     = line_s[0] & line_d[0] & ~line_d[1] & line_s[1];
endmodule

// File: rtl/i2c_idx_link.sv
module i2c_idx_link
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       wr_valid_o,
  output logic       wr_first_o,
  output logic [7:0] wr_data_o,
  output logic       rd_load_o,
  output logic       sda_oe_o
);
  link_state_e state_q;
  logic [3:0]  cnt_q;
  logic [7:0]  rx_q, tx_q;
  logic        rw_q, first_q, mack_q;

  assign wr_data_o  = rx_q;
  assign wr_first_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LS_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      rd_load_o  <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_load_o  <= 1'b0;
      if (start_i) begin
        state_q  <= LS_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= LS_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          LS_ADDR: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (rx_q[7:1] == SLV_ADDR) begin
                rw_q     <= rx_q[0];
                sda_oe_o <= 1'b1;
                state_q  <= LS_ADDR_ACK;
              end else begin
                state_q <= LS_IDLE;
              end
            end
          end
          LS_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                rd_load_o <= 1'b1;
                tx_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[7];
                cnt_q     <= 4'd1;
                state_q   <= LS_RD;
              end else begin
                sda_oe_o <= 1'b0;
                cnt_q    <= '0;
                first_q  <= 1'b1;
                state_q  <= LS_WR;
              end
            end
          end
          LS_WR: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              wr_valid_o <= 1'b1;
              sda_oe_o   <= 1'b1;
              state_q    <= LS_WR_ACK;
            end
          end
          LS_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              first_q  <= 1'b0;
              state_q  <= LS_WR;
            end
          end
          LS_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= LS_RD_ACK;
              end else begin
                sda_oe_o <= ~tx_q[6];
                tx_q     <= {tx_q[6:0], 1'b0};
                cnt_q    <= cnt_q + 4'd1;
              end
            end
          end
          LS_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                rd_load_o <= 1'b1;
                tx_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[7];
                cnt_q     <= 4'd1;
                state_q   <= LS_RD;
              end else begin
                state_q <= LS_IDLE;
              end
            end
          end
          default: state_q <= LS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_idx_nvmat.sv
module i2c_idx_nvmat #(
  parameter int ROWS = 6,
  parameter int COLS = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ptr_we_i,
  input  logic       dat_we_i,
  input  logic       step_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ptr_o,
  output logic [7:0] rdata_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int SIZE  = ROWS * COLS;
  localparam int LIN_W = $clog2(SIZE);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [7:0]       cell_q [SIZE];
  logic             hit;
  logic [LIN_W-1:0] lin;

  assign hit     = (32'(row_q) < ROWS) && (32'(col_q) < COLS);
  assign lin     = LIN_W'(32'(row_q) * COLS + 32'(col_q));
  assign ptr_o   = 8'({row_q, col_q});
  assign rdata_o = hit ? cell_q[lin] : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (ptr_we_i) begin
      row_q <= wdata_i[COL_W +: ROW_W];
      col_q <= wdata_i[0 +: COL_W];
    end else if (step_i) begin
      if (32'(col_q) >= COLS - 1) begin
        col_q <= '0;
        row_q <= (32'(row_q) >= ROWS - 1) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // erased state is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SIZE; i++) cell_q[i] <= 8'hFF;
    end else if (dat_we_i && hit) begin
      cell_q[lin] <= wdata_i;
    end
  end
endmodule

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs
  import i2c_idx_pkg::*;
#(
  parameter int         N_EVT     = 4,
  parameter int         RAM_DEPTH = 16,
  parameter int         NV_ROWS   = 6,
  parameter int         NV_COLS   = 12,
  parameter logic [7:0] ID_VAL    = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_first_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_load_i,
  output logic [7:0]       rd_data_o,
  input  logic [N_EVT-1:0] event_i,
  output logic             irq_o,
  output logic [7:0]       idx_o,
  output logic [N_EVT-1:0] stat_o
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [7:0]        idx_q, ctrl_q;
  logic [N_EVT-1:0]  stat_q, ien_q, clr;
  logic [RAM_AW-1:0] rptr_q;
  logic [7:0]        ram_q [RAM_DEPTH];
  logic              data_wr, touch, ram_port, nv_port;
  logic [7:0]        nv_ptr, nv_rdata;

  assign data_wr  = wr_valid_i & ~wr_first_i;
  assign touch    = data_wr | rd_load_i;
  assign ram_port = (idx_q == IDX_RDAT);
  assign nv_port  = (idx_q == IDX_NDAT);
  assign clr      = (data_wr && idx_q == IDX_STAT) ? wr_data_i[N_EVT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      rptr_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | event_i;
      if (wr_valid_i && wr_first_i)             idx_q <= wr_data_i;
      else if (touch && !ram_port && !nv_port)  idx_q <= idx_q + 8'd1;
      if (data_wr && idx_q == IDX_CTRL) ctrl_q <= wr_data_i;
      if (data_wr && idx_q == IDX_IEN)  ien_q  <= wr_data_i[N_EVT-1:0];
      if (data_wr && idx_q == IDX_RPTR) rptr_q <= wr_data_i[RAM_AW-1:0];
      else if (touch && ram_port)       rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else if (data_wr && ram_port) begin
      ram_q[rptr_q] <= wr_data_i;
    end
  end

  i2c_idx_nvmat #(.ROWS(NV_ROWS), .COLS(NV_COLS)) u_nvmat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ptr_we_i(data_wr && idx_q == IDX_NPTR),
    .dat_we_i(data_wr && nv_port),
    .step_i  (touch && nv_port),
    .wdata_i (wr_data_i),
    .ptr_o   (nv_ptr),
    .rdata_o (nv_rdata)
  );

  always_comb begin
    unique case (idx_q)
      IDX_CTRL: rd_data_o = ctrl_q;
      IDX_STAT: rd_data_o = 8'(stat_q);
      IDX_IEN:  rd_data_o = 8'(ien_q);
      IDX_ID:   rd_data_o = ID_VAL;
      IDX_RPTR: rd_data_o = 8'(rptr_q);
      IDX_RDAT: rd_data_o = ram_q[rptr_q];
      IDX_NPTR: rd_data_o = nv_ptr;
      IDX_NDAT: rd_data_o = nv_rdata;
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign irq_o  = |(stat_q & ien_q);
  assign idx_o  = idx_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/i2c_idx_slave.sv
module i2c_idx_slave
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'h2C,
  parameter int         N_EVT     = 4,
  parameter int         RAM_DEPTH = 16,
  parameter int         NV_ROWS   = 6,
  parameter int         NV_COLS   = 12,
  parameter logic [7:0] ID_VAL    = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [N_EVT-1:0] event_i,
  output logic             irq_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_valid, wr_first, rd_load;
  logic [7:0]       wr_data, rd_data, idx_q;
  logic [N_EVT-1:0] stat_q;

  i2c_idx_sync #(.STAGES(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_idx_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_s),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (rd_data),
    .wr_valid_o(wr_valid),
    .wr_first_o(wr_first),
    .wr_data_o (wr_data),
    .rd_load_o (rd_load),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_idx_regs #(
    .N_EVT(N_EVT), .RAM_DEPTH(RAM_DEPTH), .NV_ROWS(NV_ROWS),
    .NV_COLS(NV_COLS), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid),
    .wr_first_i(wr_first),
    .wr_data_i (wr_data),
    .rd_load_i (rd_load),
    .rd_data_o (rd_data),
    .event_i   (event_i),
    .irq_o     (irq_o),
    .idx_o     (idx_q),
    .stat_o    (stat_q)
  );
endmodule

// File: rtl/i2c_idx_chk.sv
module i2c_idx_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             irq_o,
  input logic [N_EVT-1:0] event_i,
  input logic             start_det,
  input logic             wr_valid,
  input logic             rd_load,
  input logic [7:0]       idx_q,
  input logic [N_EVT-1:0] stat_q
);
  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R12

  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o); // R11

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((stat_q & $past(event_i)) == $past(event_i))); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|event_i) || $past(wr_valid))); // R10

  AST_IDX_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_q) |-> ($past(wr_valid) || $past(rd_load))); // R4

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid && rd_load)); // R3
endmodule

bind i2c_idx_slave i2c_idx_chk #(.N_EVT(N_EVT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .irq_o    (irq_o),
  .event_i  (event_i),
  .start_det(start_det),
  .wr_valid (wr_valid),
  .rd_load  (rd_load),
  .idx_q    (idx_q),
  .stat_q   (stat_q)
);

// File: tb/i2c_idx_slave_bench.sv
module i2c_idx_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;
  localparam logic [6:0] ADDR = 7'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] ev = '0;
  logic sda_oe, irq;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit busy = 1'b1;

  // behavioural reference state
  int   m_idx = 0, m_ctrl = 0, m_st = 0, m_en = 0, m_rptr = 0, m_row = 0, m_col = 0;
  int   m_ram [16];
  int   m_nv [72];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_idx_slave u_i2c_idx_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .event_i(ev), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_hit();
    return (m_row < 6) && (m_col < 12);
  endfunction

  function automatic int m_val();
    case (m_idx)
      0: return m_ctrl;
      1: return m_st;
      2: return m_en;
      3: return 8'hA5;
      4: return m_rptr;
      5: return m_ram[m_rptr];
      6: return m_row * 16 + m_col;
      7: return m_hit() ? m_nv[m_row*12 + m_col] : 8'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic m_adv();
    if (m_idx == 5) m_rptr = (m_rptr + 1) % 16;
    else if (m_idx == 7) begin
      if (m_col >= 11) begin m_col = 0; m_row = (m_row >= 5) ? 0 : m_row + 1; end
      else m_col++;
    end else m_idx = (m_idx + 1) % 256;
  endtask

  task automatic m_wb(input int d);
    case (m_idx)
      0: m_ctrl = d;
      1: m_st = m_st & ~(d & 15);
      2: m_en = d & 15;
      4: m_rptr = d % 16;
      5: m_ram[m_rptr] = d;
      6: begin m_row = (d >> 4) & 7; m_col = d & 15; end
      7: if (m_hit()) m_nv[m_row*12 + m_col] = d;
      default: ;
    endcase
    m_adv();
  endtask

  // irq compared every idle clock; drive changes checked against raw SCL
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !busy) chk(irq == ((m_st & m_en) != 0), "R10 irq", int'(irq), int'((m_st & m_en) != 0));
    if (rst_n && sda_oe != prev_oe) chk(!scl_m, "R12 drive change with SCL high", int'(scl_m), 0);
    prev_oe = sda_oe;
  end

  task automatic hw(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H/2); scl_m = 1'b1; hw(H/2); sda_m = 1'b0; hw(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    hw(H/2); sda_m = 1'b0; hw(H/2); scl_m = 1'b1; hw(H/2); sda_m = 1'b1; hw(H/2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hw(H/2); sda_m = b[i]; hw(H/2); scl_m = 1'b1; hw(H); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    hw(H/2); sda_m = 1'b1; hw(H/2); scl_m = 1'b1; hw(H/2); ack = !sda_line; hw(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(H); scl_m = 1'b1; hw(H/2); b = {b[6:0], sda_line}; hw(H/2); scl_m = 1'b0;
    end
    hw(H/2); sda_m = !mack; hw(H/2); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(H/2); sda_m = 1'b1;
  endtask

  // write transfer: index then up to four data bytes; hold=1 leaves bus for repeated start
  task automatic wr_xfer(input int idx, input int n, input int d0, input int d1,
                         input int d2, input int d3, input bit hold);
    bit ack;
    int d [4];
    d = '{d0, d1, d2, d3};
    busy = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk(ack, "R1 own address ACK", int'(ack), 1);
    send_byte(8'(idx), ack);      chk(ack, "R2 index ACK", int'(ack), 1);
    m_idx = idx;
    for (int i = 0; i < n; i++) begin
      send_byte(8'(d[i]), ack); chk(ack, "R2 data ACK", int'(ack), 1);
      m_wb(d[i]);
    end
    if (!hold) begin bus_stop(); hw(4); busy = 1'b0; end
  endtask

  task automatic rd_xfer(input int n, input string req);
    bit ack;
    logic [7:0] b;
    int exp;
    busy = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b1}, ack); chk(ack, "R1 read address ACK", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      exp = m_val();
      m_adv();
      chk(int'(b) == exp, req, int'(b), exp);
    end
    bus_stop();
    chk(!sda_oe, "R13 SDA released after NACK", int'(sda_oe), 0);
    hw(4); busy = 1'b0;
  endtask

  task automatic pulse_ev(input logic [3:0] e);
    busy = 1'b1;
    @(negedge clk) ev = e;
    @(negedge clk) ev = '0;
    m_st = m_st | int'(e);
    busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 16; i++) m_ram[i] = 0;
    for (int i = 0; i < 72; i++) m_nv[i] = 8'hFF;
    hw(3);
    chk(!sda_oe, "R11 reset SDA released", int'(sda_oe), 0);
    chk(!irq, "R10 reset irq low", int'(irq), 0);
    rst_n = 1'b1;
    hw(4); busy = 1'b0;

    // R1: foreign address is ignored with its data bytes
    busy = 1'b1;
    bus_start();
    send_byte({7'h11, 1'b0}, ack); chk(!ack, "R1 foreign address no ACK", int'(ack), 0);
    send_byte(8'h00, ack);         chk(!ack, "R1 foreign byte no ACK", int'(ack), 0);
    send_byte(8'h5A, ack);         chk(!ack, "R1 foreign byte no ACK", int'(ack), 0);
    bus_stop(); hw(4); busy = 1'b0;
    wr_xfer(0, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R1 control untouched");

    // R2 R3: write then combined read
    wr_xfer(0, 1, 8'h3C, 0, 0, 0, 0);
    wr_xfer(0, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R3 combined read control");

    // R4 R5: burst with auto-increment, read-only id, enable upper bits
    wr_xfer(0, 4, 8'h11, 8'h00, 8'hFF, 8'h77, 0);
    wr_xfer(0, 0, 0, 0, 0, 0, 0);
    rd_xfer(4, "R4 R5 burst read");
    wr_xfer(3, 0, 0, 0, 0, 0, 0);
    rd_xfer(1, "R3 read after stop uses index");
    wr_xfer(8'h20, 1, 8'h99, 0, 0, 0, 1);
    rd_xfer(1, "R5 unmapped index");
    wr_xfer(8'hFF, 2, 8'h55, 8'h22, 0, 0, 0);
    wr_xfer(0, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R4 index wrap");

    // R6 RAM port
    wr_xfer(4, 4, 8'h0E, 8'hA1, 8'hA2, 8'hA3, 0);
    wr_xfer(4, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R6 RAM pointer wrapped");
    wr_xfer(4, 1, 8'h0E, 0, 0, 0, 1);
    rd_xfer(3, "R6 RAM burst read");
    // R13 short read advances pointer only by bytes sent
    rd_xfer(2, "R13 RAM read two");
    wr_xfer(4, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R13 pointer after NACK");

    // R7 R8 matrix
    wr_xfer(6, 4, 8'h0A, 8'h10, 8'h11, 8'h12, 0);
    wr_xfer(6, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R7 column wrap to next row");
    wr_xfer(6, 1, 8'h0A, 0, 0, 0, 1);
    rd_xfer(3, "R7 matrix burst read");
    wr_xfer(6, 2, 8'h5B, 8'h33, 0, 0, 0);
    wr_xfer(6, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R7 row wrap");
    wr_xfer(6, 2, 8'h0C, 8'h44, 0, 0, 0);
    wr_xfer(6, 0, 0, 0, 0, 0, 1);
    rd_xfer(2, "R8 invalid column skipped");
    wr_xfer(6, 1, 8'h0C, 0, 0, 0, 1);
    rd_xfer(1, "R8 invalid column reads FF");
    wr_xfer(6, 1, 8'h60, 0, 0, 0, 1);
    rd_xfer(1, "R8 invalid row reads FF");
    wr_xfer(6, 1, 8'h23, 0, 0, 0, 1);
    rd_xfer(1, "R8 erased cell");
    wr_xfer(6, 1, 8'h8A, 0, 0, 0, 0);
    wr_xfer(6, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R7 pointer bit7 reads zero");

    // R9 R10 events and interrupt
    pulse_ev(4'h2);
    hw(3);
    wr_xfer(1, 1, 8'h00, 0, 0, 0, 0);
    wr_xfer(1, 0, 0, 0, 0, 0, 1);
    rd_xfer(1, "R9 status sticky");
    wr_xfer(1, 1, 8'h02, 0, 0, 0, 0);
    hw(3);
    wr_xfer(2, 1, 8'h01, 0, 0, 0, 0);
    pulse_ev(4'h4);
    hw(3);
    wr_xfer(1, 0, 0, 0, 0, 0, 1);
    rd_xfer(2, "R9 R10 masked event");
    pulse_ev(4'h1);
    hw(3);
    wr_xfer(1, 1, 8'h05, 0, 0, 0, 0);

    // R11 STOP and START inside a byte abort it
    busy = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); send_byte(8'h00, ack);
    m_idx = 0;
    send_bits(8'hF0, 4);
    bus_stop(); hw(4);
    chk(!sda_oe, "R11 released after stop", int'(sda_oe), 0);
    busy = 1'b0;
    rd_xfer(1, "R11 partial byte discarded");
    wr_xfer(2, 0, 0, 0, 0, 0, 1);
    send_bits(8'hA8, 5);
    rd_xfer(1, "R11 restart mid byte");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule